// File: doc/BRIEF.md
# Dual-Source Output Buffer and Interrupt Arbiter

This block sits between two byte-producing input channels, a keyboard channel and an auxiliary (pointing-device) channel, and the host-facing side of a legacy input controller. Each channel presents a level that says it has a byte ready, together with that byte. The arbiter turns these levels into the output-buffer-full flags seen in the status byte, mirrors them onto two bits of the controller's output port, and drives two level interrupts: one for keyboard data and one for auxiliary data.

Keyboard data always wins. The auxiliary channel is only visible to the host, through its buffer-full flag, its interrupt and the data port, when it is the only channel holding a byte. When the host reads the data port, the arbiter returns the byte of the winning channel and sends that channel a one-cycle pop strobe so its queue can advance. The queues themselves live outside this block.

Three mode controls shape the interrupts: a keyboard interrupt enable, an auxiliary interrupt enable and a keyboard-disable bit that masks the keyboard interrupt. All outputs are registered and follow their inputs one clock later.

Top module: `obuf_irq_arbiter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, every output is 0 (`rd_data` is 8'h00).
- R2: One cycle after the inputs are sampled, `stat_obf` and `port_obf` are 1 when `kbd_pending` or `aux_pending` is 1, and 0 when both are 0.
- R3: One cycle after sampling, `stat_aux_obf` and `port_aux_obf` are 1 only when `aux_pending` is 1 and `kbd_pending` is 0.
- R4: One cycle after sampling, `irq_aux` is 1 only when `aux_pending` is 1, `kbd_pending` is 0 and `mode_aux_ie` is 1.
- R5: One cycle after sampling, `irq_kbd` is 1 only when `kbd_pending` is 1, `mode_kbd_ie` is 1 and `mode_kbd_off` is 0.
- R6: One cycle after a cycle with `rd_req` high, `rd_data` holds the sampled `aux_byte` when only the auxiliary channel was pending, and the sampled `kbd_byte` in every other case; `rd_data` keeps its value while `rd_req` is low.
- R7: One cycle after `rd_req` is sampled high, exactly one of `kbd_pop`/`aux_pop` pulses for that cycle, for the channel that supplied the byte; neither pulses when no channel was pending or when `rd_req` was low.
- R8: When a read request and a change of a pending flag fall on the same edge, the read's byte selection and pop use the pending flags sampled at that edge, the same values that set the buffer-full flags of the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kbd_pending | input | 1 | Keyboard channel has a byte ready |
| aux_pending | input | 1 | Auxiliary channel has a byte ready |
| kbd_byte | input | DATA_W | Head byte of the keyboard channel |
| aux_byte | input | DATA_W | Head byte of the auxiliary channel |
| mode_kbd_ie | input | 1 | Keyboard interrupt enable |
| mode_aux_ie | input | 1 | Auxiliary interrupt enable |
| mode_kbd_off | input | 1 | Keyboard disabled; masks the keyboard interrupt |
| rd_req | input | 1 | One-cycle data-port read request |
| stat_obf | output | 1 | Status: output buffer full |
| stat_aux_obf | output | 1 | Status: buffer holds auxiliary data |
| port_obf | output | 1 | Output-port mirror of buffer full (bit 4) |
| port_aux_obf | output | 1 | Output-port mirror of auxiliary full (bit 5) |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |
| rd_data | output | DATA_W | Byte returned by the last read |
| kbd_pop | output | 1 | One-cycle pop strobe to the keyboard channel |
| aux_pop | output | 1 | One-cycle pop strobe to the auxiliary channel |

## Verification
A data-port read and a change of the pending flags can land on the same clock edge, and then the byte selection, the pop strobe and the buffer-full flags must all agree on the same sampled flags. The bench provokes this by holding the auxiliary channel alone pending and then raising the keyboard flag in the very cycle of a read, and by the mirror case of dropping the keyboard flag while a read is issued with auxiliary data waiting. It judges the result one cycle later: the returned byte, the single pop strobe and the auxiliary-full flag must all point at the channel that the new flags make the winner.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Which channel currently owns the host-visible output buffer
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_KBD  = 2'd1,
    SRC_AUX  = 2'd2
  } arb_src_e;

  localparam int unsigned CH_KBD = 0;
  localparam int unsigned CH_AUX = 1;
  localparam int unsigned CH_N   = 2;

  function automatic arb_src_e ch_to_src(input int unsigned ch);
    return (ch == CH_KBD) ? SRC_KBD : SRC_AUX;
  endfunction

endpackage

// File: rtl/arb_src_decode.sv
module arb_src_decode
  import arb_pkg::*;
(
  input  logic     kbd_pending,
  input  logic     aux_pending,
  output arb_src_e src
);

  // Keyboard has strict priority; aux wins only when alone
  always_comb begin
    if (kbd_pending)      src = SRC_KBD;
    else if (aux_pending) src = SRC_AUX;
    else                  src = SRC_NONE;
  end

endmodule

// File: rtl/arb_flag_regs.sv
module arb_flag_regs
  import arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  arb_src_e src,
  input  logic     mode_kbd_ie,
  input  logic     mode_aux_ie,
  input  logic     mode_kbd_off,
  output logic     stat_obf,
  output logic     stat_aux_obf,
  output logic     port_obf,
  output logic     port_aux_obf,
  output logic     irq_kbd,
  output logic     irq_aux
);

  logic full_d, aux_only_d, irq_kbd_d, irq_aux_d;

  always_comb begin
    full_d     = (src != SRC_NONE);
    aux_only_d = (src == SRC_AUX);
    irq_kbd_d  = (src == SRC_KBD) && mode_kbd_ie && !mode_kbd_off;
    irq_aux_d  = aux_only_d && mode_aux_ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_obf     <= 1'b0;
      stat_aux_obf <= 1'b0;
      port_obf     <= 1'b0;
      port_aux_obf <= 1'b0;
      irq_kbd      <= 1'b0;
      irq_aux      <= 1'b0;
    end else begin
      stat_obf     <= full_d;
      stat_aux_obf <= aux_only_d;
      port_obf     <= full_d;
      port_aux_obf <= aux_only_d;
      irq_kbd      <= irq_kbd_d;
      irq_aux      <= irq_aux_d;
    end
  end

endmodule

// File: rtl/arb_read_port.sv
module arb_read_port
  import arb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  arb_src_e          src,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] kbd_byte,
  input  logic [DATA_W-1:0] aux_byte,
  output logic [DATA_W-1:0] rd_data,
  output logic [CH_N-1:0]   pop
);

  logic [DATA_W-1:0] sel_byte;

  // Aux byte only when aux alone is pending; keyboard byte otherwise
  always_comb sel_byte = (src == SRC_AUX) ? aux_byte : kbd_byte;

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_req) rd_data <= sel_byte;
  end

  // One pop strobe register per channel
  for (genvar ch = 0; ch < CH_N; ch++) begin : g_pop
    always_ff @(posedge clk) begin
      if (rst) pop[ch] <= 1'b0;
      else     pop[ch] <= rd_req && (src == ch_to_src(ch));
    end
  end

endmodule

// File: rtl/obuf_irq_arbiter.sv
module obuf_irq_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kbd_pending,
  input  logic              aux_pending,
  input  logic [DATA_W-1:0] kbd_byte,
  input  logic [DATA_W-1:0] aux_byte,
  input  logic              mode_kbd_ie,
  input  logic              mode_aux_ie,
  input  logic              mode_kbd_off,
  input  logic              rd_req,
  output logic              stat_obf,
  output logic              stat_aux_obf,
  output logic              port_obf,
  output logic              port_aux_obf,
  output logic              irq_kbd,
  output logic              irq_aux,
  output logic [DATA_W-1:0] rd_data,
  output logic              kbd_pop,
  output logic              aux_pop
);

  arb_src_e          src;
  logic [CH_N-1:0]   pop;

  arb_src_decode u_dec (
    .kbd_pending (kbd_pending),
    .aux_pending (aux_pending),
    .src         (src)
  );

  arb_flag_regs u_flags (
    .clk          (clk),
    .rst          (rst),
    .src          (src),
    .mode_kbd_ie  (mode_kbd_ie),
    .mode_aux_ie  (mode_aux_ie),
    .mode_kbd_off (mode_kbd_off),
    .stat_obf     (stat_obf),
    .stat_aux_obf (stat_aux_obf),
    .port_obf     (port_obf),
    .port_aux_obf (port_aux_obf),
    .irq_kbd      (irq_kbd),
    .irq_aux      (irq_aux)
  );

  arb_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .src      (src),
    .rd_req   (rd_req),
    .kbd_byte (kbd_byte),
    .aux_byte (aux_byte),
    .rd_data  (rd_data),
    .pop      (pop)
  );

  assign kbd_pop = pop[CH_KBD];
  assign aux_pop = pop[CH_AUX];

endmodule

// File: rtl/obuf_irq_arbiter_chk.sv
module obuf_irq_arbiter_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              kbd_pending,
  input logic              aux_pending,
  input logic [DATA_W-1:0] kbd_byte,
  input logic [DATA_W-1:0] aux_byte,
  input logic              mode_kbd_ie,
  input logic              mode_aux_ie,
  input logic              mode_kbd_off,
  input logic              rd_req,
  input logic              stat_obf,
  input logic              stat_aux_obf,
  input logic              port_obf,
  input logic              port_aux_obf,
  input logic              irq_kbd,
  input logic              irq_aux,
  input logic [DATA_W-1:0] rd_data,
  input logic              kbd_pop,
  input logic              aux_pop
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !stat_obf && !irq_kbd && !irq_aux && !kbd_pop && !aux_pop); // R1

  AST_OBF_SET: assert property (@(posedge clk) disable iff (rst)
    (kbd_pending || aux_pending) |=> (stat_obf && port_obf)); // R2

  AST_OBF_CLR: assert property (@(posedge clk) disable iff (rst)
    (!kbd_pending && !aux_pending) |=> (!stat_obf && !port_obf)); // R2

  AST_AUX_FULL_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    (stat_aux_obf || port_aux_obf) |-> stat_obf); // R3

  AST_KBD_HIDES_AUX: assert property (@(posedge clk) disable iff (rst)
    kbd_pending |=> (!stat_aux_obf && !port_aux_obf && !irq_aux)); // R3

  AST_IRQ_AUX_GATED: assert property (@(posedge clk) disable iff (rst)
    (!mode_aux_ie || !aux_pending) |=> !irq_aux); // R4

  AST_IRQ_KBD_GATED: assert property (@(posedge clk) disable iff (rst)
    (mode_kbd_off || !mode_kbd_ie || !kbd_pending) |=> !irq_kbd); // R5

  AST_RD_AUX_BYTE: assert property (@(posedge clk) disable iff (rst)
    (rd_req && aux_pending && !kbd_pending) |=> (rd_data == $past(aux_byte))); // R6

  AST_RD_KBD_BYTE: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !(aux_pending && !kbd_pending)) |=> (rd_data == $past(kbd_byte))); // R6

  AST_POP_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({kbd_pop, aux_pop})); // R7

  AST_POP_NONE: assert property (@(posedge clk) disable iff (rst)
    (!rd_req || (!kbd_pending && !aux_pending)) |=> (!kbd_pop && !aux_pop)); // R7

  AST_POP_AGREES_FLAGS: assert property (@(posedge clk) disable iff (rst)
    aux_pop |-> (stat_aux_obf && !kbd_pop)); // R8

endmodule

bind obuf_irq_arbiter obuf_irq_arbiter_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/obuf_irq_arbiter_tb.sv
module obuf_irq_arbiter_tb_top;

  localparam int unsigned DATA_W = 8;
  localparam logic [7:0]  KB = 8'h4B;
  localparam logic [7:0]  AB = 8'hA5;

  // Vector: [12]kbd [11]aux [10]kie [9]aie [8]koff [7]rd |
  //         [6]obf [5]aobf [4]irq_kbd [3]irq_aux [2]kpop [1]apop [0]rd_is_aux
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    13'b0_0_1_1_0_0__0_0_0_0_0_0_0, // idle: R2
    13'b1_0_1_1_0_0__1_0_1_0_0_0_0, // kbd only: R2 R5
    13'b1_1_1_1_0_0__1_0_1_0_0_0_0, // both: R3 priority
    13'b0_1_1_1_0_0__1_1_0_1_0_0_0, // aux only: R3 R4
    13'b0_1_1_0_0_0__1_1_0_0_0_0_0, // aux irq disabled: R4
    13'b1_0_1_1_1_0__1_0_0_0_0_0_0, // kbd disabled: R5
    13'b1_0_0_1_0_0__1_0_0_0_0_0_0, // kbd irq off: R5
    13'b0_1_1_1_0_1__1_1_0_1_0_1_1, // read aux: R6 R7
    13'b1_1_1_1_0_1__1_0_1_0_1_0_0, // read both: R6 R7
    13'b1_0_1_1_0_1__1_0_1_0_1_0_0, // read kbd: R6 R7
    13'b0_0_1_1_0_1__0_0_0_0_0_0_0, // read empty: R6 R7
    13'b1_1_0_0_1_0__1_0_0_0_0_0_0, // both, all gated: R4 R5
    13'b0_1_0_1_1_0__1_1_0_1_0_0_0, // aux, kbd masked: R4
    13'b0_0_0_0_0_0__0_0_0_0_0_0_0  // back to idle: R2
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              kbd_pending, aux_pending;
  logic [DATA_W-1:0] kbd_byte, aux_byte;
  logic              mode_kbd_ie, mode_aux_ie, mode_kbd_off;
  logic              rd_req;
  logic              stat_obf, stat_aux_obf, port_obf, port_aux_obf;
  logic              irq_kbd, irq_aux, kbd_pop, aux_pop;
  logic [DATA_W-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  obuf_irq_arbiter #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst),
    .kbd_pending(kbd_pending), .aux_pending(aux_pending),
    .kbd_byte(kbd_byte), .aux_byte(aux_byte),
    .mode_kbd_ie(mode_kbd_ie), .mode_aux_ie(mode_aux_ie),
    .mode_kbd_off(mode_kbd_off), .rd_req(rd_req),
    .stat_obf(stat_obf), .stat_aux_obf(stat_aux_obf),
    .port_obf(port_obf), .port_aux_obf(port_aux_obf),
    .irq_kbd(irq_kbd), .irq_aux(irq_aux),
    .rd_data(rd_data), .kbd_pop(kbd_pop), .aux_pop(aux_pop)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at next falling edge
  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    kbd_pending = 1'b1; aux_pending = 1'b1;
    kbd_byte = KB; aux_byte = AB;
    mode_kbd_ie = 1'b1; mode_aux_ie = 1'b1; mode_kbd_off = 1'b0;
    rd_req = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs stay quiet under reset even with inputs active
    chk("R1", "reset flags", {2'b0, stat_obf, stat_aux_obf, port_obf, port_aux_obf, irq_kbd, irq_aux}, 8'h00);
    chk("R1", "reset pops", {6'b0, kbd_pop, aux_pop}, 8'h00);
    chk("R1", "reset rd_data", rd_data, 8'h00);
    rd_req = 1'b0; kbd_pending = 1'b0; aux_pending = 1'b0;
    rst = 1'b0;
    step();

    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      v = VEC[i];
      {kbd_pending, aux_pending, mode_kbd_ie, mode_aux_ie, mode_kbd_off, rd_req} = v[12:7];
      step();
      chk("R2", $sformatf("v%0d obf", i), {6'b0, stat_obf, port_obf}, {6'b0, v[6], v[6]});
      chk("R3", $sformatf("v%0d aux_obf", i), {6'b0, stat_aux_obf, port_aux_obf}, {6'b0, v[5], v[5]});
      chk("R5", $sformatf("v%0d irq_kbd", i), {7'b0, irq_kbd}, {7'b0, v[4]});
      chk("R4", $sformatf("v%0d irq_aux", i), {7'b0, irq_aux}, {7'b0, v[3]});
      chk("R7", $sformatf("v%0d pops", i), {6'b0, kbd_pop, aux_pop}, {6'b0, v[2], v[1]});
      if (v[7]) chk("R6", $sformatf("v%0d rd_data", i), rd_data, v[0] ? AB : KB);
      rd_req = 1'b0;
    end

    // R7: pop is a single-cycle pulse; R6: rd_data held without a request
    kbd_pending = 1'b1; aux_pending = 1'b0; rd_req = 1'b1; kbd_byte = 8'h11;
    step();
    chk("R7", "pop pulse", {6'b0, kbd_pop, aux_pop}, 8'h02);
    rd_req = 1'b0; kbd_byte = 8'h22;
    step();
    chk("R7", "pop ends", {6'b0, kbd_pop, aux_pop}, 8'h00);
    chk("R6", "rd_data held", rd_data, 8'h11);

    // R8: aux alone settled, keyboard rises in the read cycle
    kbd_pending = 1'b0; aux_pending = 1'b1; aux_byte = 8'h5A; kbd_byte = 8'h3C;
    step();
    chk("R3", "aux settled", {7'b0, stat_aux_obf}, 8'h01);
    kbd_pending = 1'b1; rd_req = 1'b1;
    step();
    rd_req = 1'b0;
    chk("R8", "kbd rise byte", rd_data, 8'h3C);
    chk("R8", "kbd rise pops", {6'b0, kbd_pop, aux_pop}, 8'h02);
    chk("R8", "kbd rise aux_obf", {7'b0, stat_aux_obf}, 8'h00);

    // R8: keyboard drops in the read cycle with aux waiting
    kbd_pending = 1'b0; rd_req = 1'b1;
    step();
    rd_req = 1'b0;
    chk("R8", "kbd drop byte", rd_data, 8'h5A);
    chk("R8", "kbd drop pops", {6'b0, kbd_pop, aux_pop}, 8'h01);
    chk("R8", "kbd drop aux_obf", {7'b0, stat_aux_obf}, 8'h01);

    // R1: reset in mid-traffic clears outputs
    rst = 1'b1;
    step();
    chk("R1", "re-reset", {stat_obf, stat_aux_obf, irq_kbd, irq_aux, kbd_pop, aux_pop, 2'b0}, 8'h00);
    chk("R1", "re-reset rd_data", rd_data, 8'h00);
    rst = 1'b0;
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule